// File: doc/BRIEF.md
# Random Math Program Interpreter

This block runs a short straight-line program of 32-bit register arithmetic. The register file holds nine registers. Four of them are working registers, numbered 0 to 3, and instructions may write them. Five are read-only constants, numbered 4 to 8. A start pulse loads all nine registers at once. The program must first be written into an internal store of 71 entries through a write port.

After a start, the block fetches one instruction per clock from entry 0 upward and executes it. It stops at the first terminate opcode, or after entry 70 if no terminate opcode appears. It then raises a single-cycle done pulse. The result bus shows the four working registers. After done, they hold the final values until the next start.

Each instruction has four fields: an opcode, a 2-bit destination, a 4-bit source and a 32-bit immediate. The immediate is used only by the add operation. The operations are multiply (low half kept), add with immediate, subtract, rotate right, rotate left and XOR. In every operation the destination is also the first operand.

Top module: `rmath_engine`

## Requirements
- R1: After reset, busy and done are 0 and result is all zeros.
- R2: When start is high while the block is idle, the next clock edge loads working register i from init_var[32i+31:32i] and constant register 4+j from init_const[32j+31:32j], and sets busy.
- R3: A program write stores {prog_op, prog_dst, prog_src, prog_imm} into entry prog_addr when prog_we is high and the address is 0 to 70. A write made while busy is ignored and does not alter the program being executed.
- R4: Opcode encoding and results: 0 gives dst*src (low 32 bits), 1 gives dst+src+imm modulo 2^32, 2 gives dst-src modulo 2^32, 5 gives dst^src.
- R5: Opcode 3 rotates dst right and opcode 4 rotates it left, by src[4:0] bit positions. An amount of 0, including source values of 32 or 64, leaves dst unchanged.
- R6: The destination field selects working register 0 to 3. Source values 0 to 8 select register 0 to 8, and source values 9 to 15 read register 8.
- R7: The source operand is read before the destination is written, so when source and destination are the same register the instruction uses the old value.
- R8: Opcodes 6 and 7 terminate the run without writing any register. On the edge that executes the terminate instruction, busy falls and done rises. Done stays high for exactly one cycle, and result then holds the final working-register values until the next accepted start.
- R9: If entries 0 to 70 contain no terminate opcode, the run ends after entry 70 executes. Done and busy then behave as in R8.
- R10: A start while busy is ignored. Constant registers change only on an accepted start.
- R11: Exactly one instruction executes per clock. A run whose first terminate opcode is at entry N stays busy for N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program entry write strobe |
| prog_addr | input | 7 | Program entry index (0 to 70) |
| prog_op | input | 3 | Opcode to store |
| prog_dst | input | 2 | Destination field to store |
| prog_src | input | 4 | Source field to store |
| prog_imm | input | 32 | Immediate to store |
| start | input | 1 | Load registers and begin a run |
| init_var | input | 128 | Initial working registers, register 0 in the low bits |
| init_const | input | 160 | Constant registers 4 to 8, register 4 in the low bits |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run finishes |
| result | output | 128 | Working registers, register 0 in the low bits |

## Verification
Two situations are hard to bring about from the ports. One is a run that reaches entry 70 without terminating. The bench creates it by filling all 71 entries with non-terminate instructions and checking that the step count and final sum match. The other is a start pulse or program write that arrives mid-run. The bench fires both together a few cycles into a run: the write targets an entry that has not been reached yet, and a second run afterwards shows the write was discarded. Zero, 31 and 32 rotate amounts and multiply overflow come from constants seeded with those values, used by directed programs and by 30 random programs of random length.

// File: rtl/rmath_pkg.sv
package rmath_pkg;

    localparam int XLEN       = 32;
    localparam int NVAR       = 4;
    localparam int NCONST     = 5;
    localparam int NREG       = NVAR + NCONST;
    localparam int DST_W      = $clog2(NVAR);
    localparam int SRC_W      = $clog2(NREG);
    localparam int SH_W       = $clog2(XLEN);
    localparam int MAX_OPS    = 70;
    localparam int PROG_DEPTH = MAX_OPS + 1;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_ROR  = 3'd3,
        OP_ROL  = 3'd4,
        OP_XOR  = 3'd5,
        OP_RET  = 3'd6,
        OP_HALT = 3'd7
    } op_e;

    typedef struct packed {
        word_t             imm;
        logic [SRC_W-1:0]  src;
        logic [DST_W-1:0]  dst;
        op_e               op;
    } instr_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    // Rotate right; an amount of zero returns the input unchanged
    function automatic word_t rot_right(word_t x, logic [SH_W-1:0] n);
        if (n == '0) return x;
        return (x >> n) | (x << (XLEN - int'(n)));
    endfunction

    function automatic word_t rot_left(word_t x, logic [SH_W-1:0] n);
        if (n == '0) return x;
        return (x << n) | (x >> (XLEN - int'(n)));
    endfunction

    function automatic logic is_stop(op_e op);
        return (op == OP_RET) || (op == OP_HALT);
    endfunction

endpackage

// File: rtl/rmath_progmem.sv
module rmath_progmem
    import rmath_pkg::*;
#(
    parameter int DEPTH = PROG_DEPTH,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we_i,
    input  logic [AW-1:0]   waddr_i,
    input  instr_t          wdata_i,
    input  logic [AW-1:0]   raddr_i,
    output instr_t          rdata_o
);

    instr_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i && (int'(waddr_i) < DEPTH)) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // Out-of-range fetch reads as a terminate instruction
    always_comb begin
        rdata_o    = '0;
        rdata_o.op = OP_HALT;
        if (int'(raddr_i) < DEPTH) begin
            rdata_o = mem[raddr_i];
        end
    end

endmodule

// File: rtl/rmath_regfile.sv
module rmath_regfile
    import rmath_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic [NVAR*XLEN-1:0]    load_var_i,
    input  logic [NCONST*XLEN-1:0]  load_const_i,
    input  logic                    wr_en_i,
    input  logic [DST_W-1:0]        wr_idx_i,
    input  word_t                   wr_data_i,
    input  logic [DST_W-1:0]        dst_idx_i,
    input  logic [SRC_W-1:0]        src_idx_i,
    output word_t                   dst_val_o,
    output word_t                   src_val_o,
    output logic [NVAR*XLEN-1:0]    var_o
);

    word_t                   vreg [NVAR];
    word_t                   creg [NCONST];
    word_t                   allr [NREG];
    logic [NCONST*XLEN-1:0]  const_flat;
    logic [SRC_W-1:0]        src_sel;

    for (genvar i = 0; i < NVAR; i++) begin : g_var
        always_ff @(posedge clk) begin
            if (rst) begin
                vreg[i] <= '0;
            end else if (load_i) begin
                vreg[i] <= load_var_i[i*XLEN +: XLEN];
            end else if (wr_en_i && (wr_idx_i == DST_W'(i))) begin
                vreg[i] <= wr_data_i;
            end
        end
        assign allr[i]               = vreg[i];
        assign var_o[i*XLEN +: XLEN] = vreg[i];
    end

    for (genvar j = 0; j < NCONST; j++) begin : g_const
        always_ff @(posedge clk) begin
            if (rst) begin
                creg[j] <= '0;
            end else if (load_i) begin
                creg[j] <= load_const_i[j*XLEN +: XLEN];
            end
        end
        assign allr[NVAR+j]               = creg[j];
        assign const_flat[j*XLEN +: XLEN] = creg[j];
    end

    // Source codes beyond the last register alias to it
    assign src_sel   = (src_idx_i > SRC_W'(NREG-1)) ? SRC_W'(NREG-1) : src_idx_i;
    assign src_val_o = allr[src_sel];
    assign dst_val_o = vreg[dst_idx_i];

    // R10: constants only move on an accepted start
    assert_const_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(const_flat));

endmodule

// File: rtl/rmath_alu.sv
module rmath_alu
    import rmath_pkg::*;
(
    input  op_e    op_i,
    input  word_t  dst_i,
    input  word_t  src_i,
    input  word_t  imm_i,
    output word_t  res_o,
    output logic   wr_o
);

    logic [SH_W-1:0] amt;

    assign amt  = src_i[SH_W-1:0];
    assign wr_o = !is_stop(op_i);

    always_comb begin
        unique case (op_i)
            OP_MUL:  res_o = dst_i * src_i;
            OP_ADD:  res_o = dst_i + src_i + imm_i;
            OP_SUB:  res_o = dst_i - src_i;
            OP_ROR:  res_o = rot_right(dst_i, amt);
            OP_ROL:  res_o = rot_left(dst_i, amt);
            OP_XOR:  res_o = dst_i ^ src_i;
            default: res_o = dst_i;
        endcase
    end

    // R5: zero rotate amount leaves the operand untouched
    always_comb begin
        if (((op_i == OP_ROR) || (op_i == OP_ROL)) && (amt == '0)) begin
            assert_rot_zero_R5: assert (res_o == dst_i);
        end
    end

endmodule

// File: rtl/rmath_engine.sv
module rmath_engine
    import rmath_pkg::*;
#(
    parameter int DEPTH = PROG_DEPTH,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    prog_we,
    input  logic [AW-1:0]           prog_addr,
    input  logic [2:0]              prog_op,
    input  logic [DST_W-1:0]        prog_dst,
    input  logic [SRC_W-1:0]        prog_src,
    input  logic [XLEN-1:0]         prog_imm,
    input  logic                    start,
    input  logic [NVAR*XLEN-1:0]    init_var,
    input  logic [NCONST*XLEN-1:0]  init_const,
    output logic                    busy,
    output logic                    done,
    output logic [NVAR*XLEN-1:0]    result
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    state_e        state;
    logic [AW-1:0] pc;
    instr_t        wr_instr;
    instr_t        cur;
    word_t         dst_val, src_val, alu_res;
    logic          alu_wr;
    logic          accept;
    logic          finish;

    assign busy   = (state == ST_RUN);
    assign accept = start && (state == ST_IDLE);
    assign finish = busy && (is_stop(cur.op) || (pc == LAST));

    always_comb begin
        wr_instr     = '0;
        wr_instr.op  = op_e'(prog_op);
        wr_instr.dst = prog_dst;
        wr_instr.src = prog_src;
        wr_instr.imm = prog_imm;
    end

    rmath_progmem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .we_i    (prog_we && !busy),
        .waddr_i (prog_addr),
        .wdata_i (wr_instr),
        .raddr_i (pc),
        .rdata_o (cur)
    );

    rmath_regfile u_rf (
        .clk          (clk),
        .rst          (rst),
        .load_i       (accept),
        .load_var_i   (init_var),
        .load_const_i (init_const),
        .wr_en_i      (busy && alu_wr),
        .wr_idx_i     (cur.dst),
        .wr_data_i    (alu_res),
        .dst_idx_i    (cur.dst),
        .src_idx_i    (cur.src),
        .dst_val_o    (dst_val),
        .src_val_o    (src_val),
        .var_o        (result)
    );

    rmath_alu u_alu (
        .op_i  (cur.op),
        .dst_i (dst_val),
        .src_i (src_val),
        .imm_i (cur.imm),
        .res_o (alu_res),
        .wr_o  (alu_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pc    <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        pc    <= '0;
                    end
                end
                ST_RUN: begin
                    if (finish) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        pc <= pc + AW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: done is a single-cycle pulse and never overlaps busy
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: the fetch index never leaves the program store
    assert_pc_bound_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(pc) < DEPTH));

    // R10: a start during a run does not restart it
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (done || (pc != '0)));

    // R11: non-terminating steps advance by exactly one entry
    assert_step_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !is_stop(cur.op) && (pc != LAST)) |=> (busy && (pc == $past(pc) + AW'(1))));

endmodule

// File: tb/sim_rmath_engine.sv
`timescale 1ns/1ps
module sim_rmath_engine;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         prog_we = 1'b0;
    logic [6:0]   prog_addr = '0;
    logic [2:0]   prog_op = '0;
    logic [1:0]   prog_dst = '0;
    logic [3:0]   prog_src = '0;
    logic [31:0]  prog_imm = '0;
    logic         start = 1'b0;
    logic [127:0] init_var = '0;
    logic [159:0] init_const = '0;
    wire          busy;
    wire          done;
    wire  [127:0] result;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    rmath_engine u0 (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_op(prog_op), .prog_dst(prog_dst), .prog_src(prog_src),
        .prog_imm(prog_imm), .start(start), .init_var(init_var),
        .init_const(init_const), .busy(busy), .done(done), .result(result)
    );

    // ---------------- reference model ----------------
    logic [2:0]   m_op  [0:70];
    logic [1:0]   m_dst [0:70];
    logic [3:0]   m_src [0:70];
    logic [31:0]  m_imm [0:70];
    bit           m_busy = 0;
    bit           m_done = 0;
    int           m_left = 0;
    logic [127:0] m_res = '0;
    logic [127:0] m_final = '0;

    function automatic logic [31:0] bit_rot(logic [31:0] x, int n, bit left);
        for (int i = 0; i < n; i++) begin
            x = left ? {x[30:0], x[31]} : {x[0], x[31:1]};
        end
        return x;
    endfunction

    function automatic void model_run(input logic [127:0] v, input logic [159:0] c,
                                       output logic [127:0] fin, output int steps);
        logic [31:0] r [0:8];
        logic [31:0] a, b;
        int s;
        for (int i = 0; i < 4; i++) r[i] = v[i*32 +: 32];
        for (int j = 0; j < 5; j++) r[4+j] = c[j*32 +: 32];
        steps = 71;
        for (int k = 0; k < 71; k++) begin
            if (m_op[k] >= 3'd6) begin
                steps = k + 1;
                break;
            end
            s = (m_src[k] > 4'd8) ? 8 : int'(m_src[k]);
            b = r[s];
            a = r[m_dst[k]];
            case (m_op[k])
                3'd0: a = a * b;
                3'd1: a = a + b + m_imm[k];
                3'd2: a = a - b;
                3'd3: a = bit_rot(a, int'(b % 32), 1'b0);
                3'd4: a = bit_rot(a, int'(b % 32), 1'b1);
                default: a = a ^ b;
            endcase
            r[m_dst[k]] = a;
        end
        for (int i = 0; i < 4; i++) fin[i*32 +: 32] = r[i];
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 0;
            m_done = 0;
            m_res  = '0;
        end else begin
            m_done = 0;
            if (prog_we && !m_busy && prog_addr < 7'd71) begin
                m_op[prog_addr]  = prog_op;
                m_dst[prog_addr] = prog_dst;
                m_src[prog_addr] = prog_src;
                m_imm[prog_addr] = prog_imm;
            end
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    m_res  = m_final;
                end
            end else if (start) begin
                model_run(init_var, init_const, m_final, m_left);
                m_busy = 1;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (busy !== m_busy || done !== m_done) begin
                fails++;
                $display("FAIL R8/R11 cycle %0d: busy=%0b done=%0b expected busy=%0b done=%0b",
                         cyc, busy, done, m_busy, m_done);
            end
            if (!m_busy) begin
                checks++;
                if (result !== m_res) begin
                    fails++;
                    $display("FAIL R8 held result cycle %0d: got %h expected %h", cyc, result, m_res);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic put_instr(input int addr, input logic [2:0] op, input logic [1:0] dst,
                             input logic [3:0] src, input logic [31:0] imm);
        @(negedge clk);
        prog_we   = 1'b1;
        prog_addr = 7'(addr);
        prog_op   = op;
        prog_dst  = dst;
        prog_src  = src;
        prog_imm  = imm;
        @(negedge clk);
        prog_we   = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (!done) begin
            fails++;
            $display("FAIL %s: no done pulse, got done=%0b expected 1", tag, done);
        end else if (result !== m_final) begin
            fails++;
            $display("FAIL %s: result %h expected %h", tag, result, m_final);
        end
    endtask

    task automatic run_prog(input string tag, input logic [127:0] v, input logic [159:0] c);
        @(negedge clk);
        init_var   = v;
        init_const = c;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        wait_done(tag);
    endtask

    logic [159:0] kc;
    logic [127:0] kv;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || result !== '0) begin
            fails++;
            $display("FAIL R1: busy=%0b done=%0b result=%h expected 0 0 0", busy, done, result);
        end

        kc = {32'h0000_003F, 32'h0000_0020, 32'h0000_001F, 32'h0000_0000, 32'hFFFF_FFFF};
        kv = {32'h8000_0001, 32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_FFF0};

        // R2: terminate at entry 0, result equals loaded values
        put_instr(0, 3'd6, 2'd0, 4'd0, 32'h0);
        run_prog("R2", kv, kc);

        // R4: arithmetic with overflow (R4 is 0xFFFFFFFF)
        put_instr(0, 3'd0, 2'd0, 4'd4, 32'h0);
        put_instr(1, 3'd1, 2'd1, 4'd4, 32'hFFFF_FFFF);
        put_instr(2, 3'd2, 2'd2, 4'd8, 32'h0);
        put_instr(3, 3'd5, 2'd3, 4'd4, 32'h0);
        put_instr(4, 3'd0, 2'd3, 4'd3, 32'h0);
        put_instr(5, 3'd6, 2'd0, 4'd0, 32'h0);
        run_prog("R4", kv, kc);

        // R5: rotate by 0, 31, 32 and 63
        put_instr(0, 3'd3, 2'd0, 4'd5, 32'h0);
        put_instr(1, 3'd4, 2'd1, 4'd6, 32'h0);
        put_instr(2, 3'd3, 2'd2, 4'd7, 32'h0);
        put_instr(3, 3'd4, 2'd3, 4'd8, 32'h0);
        put_instr(4, 3'd3, 2'd1, 4'd6, 32'h0);
        put_instr(5, 3'd6, 2'd0, 4'd0, 32'h0);
        run_prog("R5", kv, kc);

        // R6 / R7: same-register operands, source aliasing, opcode 7 stop
        put_instr(0, 3'd2, 2'd1, 4'd1, 32'h0);
        put_instr(1, 3'd5, 2'd2, 4'd2, 32'h0);
        put_instr(2, 3'd1, 2'd0, 4'd0, 32'h0000_0005);
        put_instr(3, 3'd0, 2'd3, 4'd12, 32'h0);
        put_instr(4, 3'd1, 2'd2, 4'd15, 32'h0000_0100);
        put_instr(5, 3'd7, 2'd0, 4'd0, 32'h0);
        run_prog("R6/R7", kv, kc);

        // R9: no terminate in any entry
        for (int k = 0; k < 71; k++) put_instr(k, 3'd1, 2'd0, 4'd5, 32'h1);
        run_prog("R9", kv, kc);

        // R10 / R3: restart and program write during a run are ignored
        for (int k = 0; k < 20; k++) put_instr(k, 3'd5, 2'(k % 4), 4'(4 + k % 5), 32'h0);
        put_instr(20, 3'd6, 2'd0, 4'd0, 32'h0);
        @(negedge clk);
        init_var = kv; init_const = kc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; init_var = ~kv; init_const = ~kc;
        prog_we = 1'b1; prog_addr = 7'd15; prog_op = 3'd6; prog_dst = 2'd0; prog_src = 4'd0; prog_imm = '0;
        @(negedge clk);
        start = 1'b0; prog_we = 1'b0;
        wait_done("R10");
        run_prog("R3", ~kv, kc);

        // R4..R7, R11: random programs
        for (int p = 0; p < 30; p++) begin
            int len;
            len = 1 + int'($urandom % 70);
            for (int k = 0; k < len; k++)
                put_instr(k, 3'($urandom % 6), 2'($urandom), 4'($urandom), $urandom);
            put_instr(len, 3'(6 + $urandom % 2), 2'd0, 4'd0, 32'h0);
            run_prog("R11 random", {$urandom, $urandom, $urandom, $urandom},
                     {kc[159:96], $urandom, $urandom, kc[31:0]});
        end

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        fails++;
        $display("FAIL watchdog: cycles=%0d expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule